// File: doc/BRIEF.md
# Packed Lane Add-Subtract Unit

This unit treats each operand word as a row of independent integer lanes and adds or subtracts them lane by lane in one pass. A two-bit size code selects the lane width: 8, 16 or 32 bits. A four-bit operation code selects the arithmetic. The plain forms wrap around. The halving forms keep the carry bit before they shift. The saturating forms clamp each lane to its limits. The narrowing forms keep only the upper half of each lane's sum or difference and pack those halves into the low half of the result. A signedness input selects how lane values are read. That choice matters to halving and saturation only.

Operands are sampled on a clock edge while `in_valid` is high. The result is held in a register, and `out_valid` goes high in the following cycle. A small output state machine has two states. `ST_IDLE` means no fresh result is present. `ST_RESULT` means the register holds the result of the previous cycle's operands. The transition IDLE→RESULT fires on `in_valid`. RESULT→RESULT also fires on `in_valid`, when operands arrive back to back. RESULT→IDLE fires when `in_valid` is low, and IDLE→IDLE likewise.

A sticky flag records that at least one lane clamped since the flag was last cleared. The flag is cleared through `sat_clr`.

Top module: `laneadd_unit`

## Requirements
- R1: The size code selects the lane width: 0 gives 8 bits, 1 gives 16 bits, and 2 or 3 give 32 bits. No carry or borrow passes from one lane into the next; for example, 8-bit lanes of 0xFF plus 0x01 give 0x00 in every lane.
- R2: Code 0 returns the wrapped lane sum a+b. Code 1 returns the wrapped lane difference a−b.
- R3: Code 2 returns (a+b)>>1 and code 3 returns (a+b+1)>>1, both with the carry bit kept. Lanes are sign-extended when `is_signed`=1 and zero-extended otherwise. Signed 8-bit 127+127 gives 127, and unsigned 0xFF+0xFF gives 0xFF.
- R4: Code 4 returns (a−b)>>1, shifted arithmetically in signed mode. Signed 1−3 gives −1 (all ones).
- R5: Code 5 (add) and code 6 (subtract) clamp each lane to its limit on overflow. In signed mode the limits are 2^(W−1)−1 and −2^(W−1). In unsigned mode they are 2^W−1 and 0. Signed 8-bit 127+1 gives 127, and −128+(−1) gives −128.
- R6: Codes 7 (add) and 9 (subtract) return the upper W/2 bits of each lane's wrapped W-bit result. Codes 8 and 10 do the same after adding 1<<(W/2−1). Lane i's half goes to result bits [i·W/2 +: W/2], and the upper half of the result is zero. For 32-bit lanes, 0x7ffffffe+2 gives 0x8000, and 0x7ffffffe+1 rounded gives 0x8000.
- R7: Codes 11 to 15 give a zero result and never set the saturation flag.
- R8: `sat_flag` is set at the edge that samples an operation in which any lane clamped. It stays set until an edge with `sat_clr`=1. A clamp in that same cycle keeps it set.
- R9: `result` changes only at edges where `in_valid`=1.
- R10: `out_valid` is high exactly in the cycle after an edge that sampled `in_valid`=1. Reset clears `result`, `out_valid` and `sat_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Operands and controls are valid this cycle |
| op | input | 4 | Operation code |
| esize | input | 2 | Lane width select |
| is_signed | input | 1 | Signed lane interpretation |
| a | input | VEC_W | First operand vector |
| b | input | VEC_W | Second operand vector |
| sat_clr | input | 1 | Clears the sticky saturation flag |
| out_valid | output | 1 | Registered result is fresh |
| result | output | VEC_W | Registered lane results |
| sat_flag | output | 1 | Sticky saturation indicator |

## Verification
The hardest case to reach is a single edge where a clear and a fresh clamp collide. In that case the flag must stay set. When the clear comes with a non-clamping operation, it must drop. The stimulus reaches both by first forcing a clamp in one 8-bit lane while every other lane stays in range. It then issues the clear together with a second clamping operation, and again together with a plain add, so that the scoreboard compares the flag after each. Lane isolation is driven with all-ones operands, so any carry leaking between lanes would show in the next lane.

// File: rtl/laneadd_pkg.sv
package laneadd_pkg;

    typedef enum logic [3:0] {
        OP_ADD    = 4'd0,
        OP_SUB    = 4'd1,
        OP_HADD   = 4'd2,
        OP_RHADD  = 4'd3,
        OP_HSUB   = 4'd4,
        OP_QADD   = 4'd5,
        OP_QSUB   = 4'd6,
        OP_ADDHI  = 4'd7,
        OP_RADDHI = 4'd8,
        OP_SUBHI  = 4'd9,
        OP_RSUBHI = 4'd10
    } lane_op_e;

    typedef enum logic [1:0] {
        SZ_8  = 2'd0,
        SZ_16 = 2'd1,
        SZ_32 = 2'd2
    } elem_size_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_RESULT = 1'b1
    } out_state_e;

    localparam int NUM_SIZES = 3;

endpackage

// File: rtl/lane_alu.sv
module lane_alu
    import laneadd_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [3:0]    op,
    input  logic          is_signed,
    input  logic [W-1:0]  a,
    input  logic [W-1:0]  b,
    output logic [W-1:0]  wide_o,
    output logic [W/2-1:0] narrow_o,
    output logic          sat_o
);
    localparam int EW = W + 1;
    localparam int HW = W / 2;

    logic [EW-1:0] ae, be, sum, dif;
    logic [W-1:0]  ha, hb;
    logic [W-1:0]  half_add, half_radd, half_sub;
    logic [W-1:0]  max_v, min_v;
    logic          add_ovf, sub_ovf;
    logic [W-1:0]  add_clamp, sub_clamp;
    logic [HW-1:0] hi_sum, hi_dif, rhi_sum, rhi_dif;

    // Extension by mode; one spare bit keeps every carry and borrow.
    assign ae  = is_signed ? {a[W-1], a} : {1'b0, a};
    assign be  = is_signed ? {b[W-1], b} : {1'b0, b};
    assign sum = ae + be;
    assign dif = ae - be;

    // Halving from pre-shifted halves plus a low-bit fixup.
    assign ha        = ae[W:1];
    assign hb        = be[W:1];
    assign half_add  = ha + hb + W'(a[0] & b[0]);
    assign half_radd = ha + hb + W'(a[0] | b[0]);
    assign half_sub  = ha - hb - W'(~a[0] & b[0]);

    // Clamp limits.
    assign max_v = is_signed ? {1'b0, {(W-1){1'b1}}} : {W{1'b1}};
    assign min_v = is_signed ? {1'b1, {(W-1){1'b0}}} : {W{1'b0}};

    assign add_ovf   = is_signed ? (sum[W] ^ sum[W-1]) : sum[W];
    assign sub_ovf   = is_signed ? (dif[W] ^ dif[W-1]) : dif[W];
    assign add_clamp = (is_signed && sum[W]) ? min_v : max_v;
    assign sub_clamp = (is_signed && !dif[W]) ? max_v : min_v;

    // Upper halves; rounding carry equals bit HW-1 of the wide result.
    assign hi_sum  = sum[W-1:HW];
    assign hi_dif  = dif[W-1:HW];
    assign rhi_sum = hi_sum + HW'(sum[HW-1]);
    assign rhi_dif = hi_dif + HW'(dif[HW-1]);

    always_comb begin
        wide_o   = '0;
        narrow_o = '0;
        sat_o    = 1'b0;
        unique case (op)
            OP_ADD:    wide_o = sum[W-1:0];
            OP_SUB:    wide_o = dif[W-1:0];
            OP_HADD:   wide_o = half_add;
            OP_RHADD:  wide_o = half_radd;
            OP_HSUB:   wide_o = half_sub;
            OP_QADD: begin
                wide_o = add_ovf ? add_clamp : sum[W-1:0];
                sat_o  = add_ovf;
            end
            OP_QSUB: begin
                wide_o = sub_ovf ? sub_clamp : dif[W-1:0];
                sat_o  = sub_ovf;
            end
            OP_ADDHI:  narrow_o = hi_sum;
            OP_RADDHI: narrow_o = rhi_sum;
            OP_SUBHI:  narrow_o = hi_dif;
            OP_RSUBHI: narrow_o = rhi_dif;
            default: begin
                wide_o   = '0;
                narrow_o = '0;
                sat_o    = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/lane_bank.sv
module lane_bank #(
    parameter int VEC_W = 128,
    parameter int W     = 8
) (
    input  logic [3:0]         op,
    input  logic               is_signed,
    input  logic [VEC_W-1:0]   a,
    input  logic [VEC_W-1:0]   b,
    output logic [VEC_W-1:0]   wide_o,
    output logic [VEC_W/2-1:0] narrow_o,
    output logic               sat_o
);
    localparam int LANES = VEC_W / W;
    localparam int HW    = W / 2;

    logic [LANES-1:0] lane_sat;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        lane_alu #(.W(W)) u_lane (
            .op        (op),
            .is_signed (is_signed),
            .a         (a[i*W +: W]),
            .b         (b[i*W +: W]),
            .wide_o    (wide_o[i*W +: W]),
            .narrow_o  (narrow_o[i*HW +: HW]),
            .sat_o     (lane_sat[i])
        );
    end

    assign sat_o = |lane_sat;

endmodule

// File: rtl/laneadd_unit.sv
module laneadd_unit
    import laneadd_pkg::*;
#(
    parameter int VEC_W = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [3:0]       op,
    input  logic [1:0]       esize,
    input  logic             is_signed,
    input  logic [VEC_W-1:0] a,
    input  logic [VEC_W-1:0] b,
    input  logic             sat_clr,
    output logic             out_valid,
    output logic [VEC_W-1:0] result,
    output logic             sat_flag
);
    localparam int HALF_W = VEC_W / 2;

    logic [VEC_W-1:0]  bank_wide   [NUM_SIZES];
    logic [HALF_W-1:0] bank_narrow [NUM_SIZES];
    logic [NUM_SIZES-1:0] bank_sat;

    for (genvar g = 0; g < NUM_SIZES; g++) begin : g_bank
        lane_bank #(.VEC_W(VEC_W), .W(8 << g)) u_bank (
            .op        (op),
            .is_signed (is_signed),
            .a         (a),
            .b         (b),
            .wide_o    (bank_wide[g]),
            .narrow_o  (bank_narrow[g]),
            .sat_o     (bank_sat[g])
        );
    end

    logic [VEC_W-1:0]  sel_wide;
    logic [HALF_W-1:0] sel_narrow;
    logic              sel_sat;
    logic              is_narrow;
    logic [VEC_W-1:0]  next_result;

    always_comb begin
        unique case (esize)
            SZ_8: begin
                sel_wide = bank_wide[0]; sel_narrow = bank_narrow[0]; sel_sat = bank_sat[0];
            end
            SZ_16: begin
                sel_wide = bank_wide[1]; sel_narrow = bank_narrow[1]; sel_sat = bank_sat[1];
            end
            default: begin
                sel_wide = bank_wide[2]; sel_narrow = bank_narrow[2]; sel_sat = bank_sat[2];
            end
        endcase
    end

    assign is_narrow   = (op == OP_ADDHI) || (op == OP_RADDHI) ||
                         (op == OP_SUBHI) || (op == OP_RSUBHI);
    assign next_result = is_narrow ? {{HALF_W{1'b0}}, sel_narrow} : sel_wide;

    // Output state machine.
    out_state_e state, state_nx;

    always_comb begin
        unique case (state)
            ST_IDLE:   state_nx = in_valid ? ST_RESULT : ST_IDLE;
            ST_RESULT: state_nx = in_valid ? ST_RESULT : ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    assign out_valid = (state == ST_RESULT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result   <= '0;
            sat_flag <= 1'b0;
        end else begin
            if (in_valid) result <= next_result;
            sat_flag <= (sat_flag && !sat_clr) || (in_valid && sel_sat);
        end
    end

    // Checks next to the logic they guard.
    assert_valid_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_valid_drops_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    assert_hold_result_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result));
    assert_sticky_sat_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sat_flag && !sat_clr) |=> sat_flag);
    assert_clear_sat_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sat_clr && !(in_valid && sel_sat)) |=> !sat_flag);
    assert_narrow_upper_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && is_narrow) |=> (result[VEC_W-1:HALF_W] == '0));
    assert_reserved_nosat_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op > 4'd10 && !sat_flag) |=> !sat_flag);

endmodule

// File: tb/laneadd_unit_bench.sv
`timescale 1ns/1ps
module laneadd_unit_bench;
    localparam int VW = 128;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          in_valid, is_signed, sat_clr;
    logic [3:0]    op;
    logic [1:0]    esize;
    logic [VW-1:0] a, b;
    logic          out_valid, sat_flag;
    logic [VW-1:0] result;

    always #4 clk = ~clk;

    laneadd_unit #(.VEC_W(VW)) u_laneadd_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .esize(esize),
        .is_signed(is_signed), .a(a), .b(b), .sat_clr(sat_clr),
        .out_valid(out_valid), .result(result), .sat_flag(sat_flag)
    );

    typedef struct {
        logic [VW-1:0] res;
        bit            sat;
        string         tag;
    } exp_t;

    exp_t          sb[$];
    int            n_run = 0;
    int            n_fail = 0;
    bit            sticky = 1'b0;
    logic [VW-1:0] last_res = '0;
    logic [31:0]   seed = 32'h1234_5678;

    function automatic logic [VW-1:0] model(input int opc, input int es, input bit sg,
                                            input logic [VW-1:0] x_v, input logic [VW-1:0] y_v,
                                            output bit sat);
        int w = (es == 0) ? 8 : (es == 1) ? 16 : 32;
        int h = w / 2;
        longint mask = (longint'(1) << w) - 1;
        longint hmask = (longint'(1) << h) - 1;
        longint maxv = sg ? ((longint'(1) << (w-1)) - 1) : mask;
        longint minv = sg ? -(longint'(1) << (w-1)) : 0;
        logic [VW-1:0] r = '0;
        sat = 1'b0;
        for (int i = 0; i < VW / w; i++) begin
            longint x, y, s, res;
            logic [VW-1:0] t;
            bit narrow = 1'b0;
            x = longint'(x_v >> (i*w)) & mask;
            y = longint'(y_v >> (i*w)) & mask;
            if (sg && x[w-1]) x = x - (longint'(1) << w);
            if (sg && y[w-1]) y = y - (longint'(1) << w);
            case (opc)
                0: res = x + y;
                1: res = x - y;
                2: res = (x + y) >>> 1;
                3: res = (x + y + 1) >>> 1;
                4: res = (x - y) >>> 1;
                5, 6: begin
                    s = (opc == 5) ? x + y : x - y;
                    if (s > maxv) begin res = maxv; sat = 1'b1; end
                    else if (s < minv) begin res = minv; sat = 1'b1; end
                    else res = s;
                end
                7, 8, 9, 10: begin
                    s = (opc <= 8) ? x + y : x - y;
                    if (opc == 8 || opc == 10) s = s + (longint'(1) << (h-1));
                    res = s >>> h;
                    narrow = 1'b1;
                end
                default: res = 0;
            endcase
            t = '0;
            if (narrow) begin
                t[63:0] = res & hmask;
                r = r | (t << (i*h));
            end else begin
                t[63:0] = res & mask;
                r = r | (t << (i*w));
            end
        end
        return r;
    endfunction

    function automatic string tag_for(input int opc);
        case (opc)
            0, 1:         return "R2";
            2, 3:         return "R3";
            4:            return "R4";
            5, 6:         return "R5";
            7, 8, 9, 10:  return "R6";
            default:      return "R7";
        endcase
    endfunction

    function automatic logic [31:0] rnd();
        seed = seed * 32'd1664525 + 32'd1013904223;
        return seed;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [VW-1:0] act,
                         input logic [VW-1:0] expv);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual %h expected %h", tag, act, expv);
        end
    endtask

    task automatic drive(input int opc, input int es, input bit sg,
                         input logic [VW-1:0] x_v, input logic [VW-1:0] y_v,
                         input bit clr, input string tag);
        exp_t e;
        bit s;
        @(negedge clk);
        in_valid = 1'b1; op = 4'(opc); esize = 2'(es); is_signed = sg;
        a = x_v; b = y_v; sat_clr = clr;
        e.res = model(opc, es, sg, x_v, y_v, s);
        sticky = (sticky && !clr) || s;
        e.sat = sticky;
        e.tag = tag;
        last_res = e.res;
        sb.push_back(e);
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0; sat_clr = 1'b0;
    endtask

    // Monitor: compares each fresh result against the scoreboard head.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && out_valid) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R10 unexpected out_valid", {127'b0, out_valid}, '0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(result === e.res, {e.tag, " result"}, result, e.res);
                    check(sat_flag === e.sat, "R8 sat_flag", {127'b0, sat_flag}, {127'b0, e.sat});
                end
            end
        end
    end

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL R10 watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; op = '0; esize = '0; is_signed = 1'b0;
        a = '0; b = '0; sat_clr = 1'b0;
        repeat (3) @(negedge clk);
        check(result === '0, "R10 reset result", result, '0);
        check(out_valid === 1'b0, "R10 reset out_valid", {127'b0, out_valid}, '0);
        check(sat_flag === 1'b0, "R10 reset sat_flag", {127'b0, sat_flag}, '0);
        rst_n = 1'b1;

        // R1: lane isolation at every width, including size code 3.
        drive(0, 0, 0, {VW{1'b1}}, {16{8'h01}}, 0, "R1 8-bit no carry");
        drive(0, 1, 0, {VW{1'b1}}, {8{16'h0001}}, 0, "R1 16-bit no carry");
        drive(1, 2, 0, '0, {4{32'h1}}, 0, "R1 32-bit no borrow");
        drive(0, 3, 0, {VW{1'b1}}, {4{32'h1}}, 0, "R1 size code 3 as 32");
        // R2
        drive(1, 0, 1, {16{8'h05}}, {16{8'h07}}, 0, "R2 sub wrap");
        // R3
        drive(2, 0, 1, {16{8'h7f}}, {16{8'h7f}}, 0, "R3 signed halving keeps carry");
        drive(2, 0, 0, {16{8'hff}}, {16{8'hff}}, 0, "R3 unsigned halving keeps carry");
        drive(3, 2, 1, {4{32'h1}}, {4{32'h2}}, 0, "R3 rounding halving");
        // R4
        drive(4, 2, 1, {4{32'h1}}, {4{32'h3}}, 0, "R4 signed halving sub");
        drive(4, 1, 0, {8{16'h0001}}, {8{16'h0003}}, 0, "R4 unsigned halving sub");
        // R5
        drive(5, 0, 1, {16{8'h7f}}, {16{8'h01}}, 0, "R5 signed clamp high");
        drive(5, 0, 1, {16{8'h80}}, {16{8'hff}}, 0, "R5 signed clamp low");
        drive(6, 1, 0, '0, {8{16'h1}}, 0, "R5 unsigned sub clamp zero");
        // R6
        drive(7, 2, 1, {4{32'h7ffffffe}}, {4{32'h2}}, 0, "R6 high half add");
        drive(8, 2, 1, {4{32'h7ffffffe}}, {4{32'h1}}, 0, "R6 rounded high half add");
        drive(10, 2, 1, {4{32'h7fffeeee}}, {4{32'h0000000f}}, 0, "R6 rounded high half sub");
        drive(9, 1, 0, {8{16'h1234}}, {8{16'h0034}}, 0, "R6 high half sub 16");
        // R7
        drive(12, 0, 1, {16{8'h7f}}, {16{8'h7f}}, 0, "R7 reserved code");

        // R9/R10: hold and valid drop.
        idle();
        @(negedge clk);
        check(out_valid === 1'b0, "R10 out_valid low after idle", {127'b0, out_valid}, '0);
        check(result === last_res, "R9 result held", result, last_res);

        // R8: clear alone, then one-lane clamp, clear collisions.
        @(negedge clk); sat_clr = 1'b1; sticky = 1'b0;
        @(negedge clk); sat_clr = 1'b0;
        check(sat_flag === 1'b0, "R8 clear alone", {127'b0, sat_flag}, '0);
        drive(5, 0, 1, {{15{8'h10}}, 8'h7f}, {{15{8'h01}}, 8'h01}, 0, "R8 one-lane clamp");
        drive(0, 0, 1, '0, '0, 0, "R8 sticky through add");
        drive(5, 0, 1, {16{8'h7f}}, {16{8'h7f}}, 1, "R8 clamp wins over clear");
        drive(0, 0, 1, '0, '0, 1, "R8 clear with plain add");

        // Mixed patterns across codes, widths and modes.
        for (int k = 0; k < 80; k++) begin
            logic [VW-1:0] x_v, y_v;
            x_v = {rnd(), rnd(), rnd(), rnd()};
            y_v = {rnd(), rnd(), rnd(), rnd()};
            drive(k % 13, (k / 13) % 4, k[0], x_v, y_v, (k % 7) == 0, tag_for(k % 13));
            if ((k % 5) == 4) idle();
        end
        idle();
        repeat (3) @(negedge clk);
        check(sb.size() == 0, "R10 all results seen", VW'(sb.size()), '0);
        finish_run();
    end

endmodule